// File: doc/BRIEF.md
# Flash Mass-Erase Sequencer

This block is the register front end of an on-chip flash controller, cut down to the path that wipes the whole array. A bus master reaches it through a zero-wait APB-style register port. To wipe the array, software writes a control word that carries an unlock key, an erase code and a start bit. If the key and the code match and the debug-port-enable input is high, the block enters a busy phase of a fixed number of cycles. During that phase every word of the built-in flash array model is driven to all ones.

If the request is malformed, or the debug port is disabled, nothing is erased and a sticky failure flag is raised instead. Completion and failure are both recorded as sticky flags that software clears by writing ones. Each flag can raise the interrupt line through its own enable bit.

The sequencer has three states: IDLE, ERASE and REJECT. It has five transitions:
- IDLE to ERASE when a valid start is accepted.
- IDLE to REJECT when a start is refused.
- ERASE to ERASE while the countdown is not yet zero.
- ERASE to IDLE when the countdown reaches zero, which raises the done flag.
- REJECT to IDLE after one cycle, which raises the failure flag.

Top module: `flash_mass_erase`

## Requirements
- R1: After reset, every register reads 0, the interrupt output is low, and every flash array word reads 0 through the window.
- R2: The address pointer sits at offset 0x00 (32 bits, read/write). The clock divisor sits at 0x04 (low CDIV_W bits read/write, upper bits read 0). Four data words sit at 0x30, 0x34, 0x38 and 0x3C (read/write). Reads of unmapped offsets return 0.
- R3: A write to the control register at 0x08 with bit 0 (start) set starts an erase only if three conditions hold: key field [31:28] equals 0x2, code field [15:8] equals 0xAA, and dbg_en is high.
- R4: From the clock edge that accepts the start, control bit 24 (busy) and control bit 0 read 1 for exactly ERASE_CYCLES cycles, and then both read 0.
- R5: The done flag (bit 0 of the interrupt register at 0x24) becomes 1 on the same edge at which busy falls.
- R6: While busy, every flash word is driven to all ones. Offset 0x40 reads the flash word selected by address-pointer bits [IDX_W+1:2]. A refused request leaves the array unchanged.
- R7: A start that is refused, because dbg_en is low or because the key or code is wrong, sets the fail flag (bit 1 of 0x24) one cycle after the write edge, and busy stays 0.
- R8: Writes to the control register while the sequencer is not idle are ignored. They do not change the stored fields, the busy length, or the flags.
- R9: The irq output is high exactly when a set flag has its enable bit set. Bit 8 of 0x24 enables done and bit 9 enables fail.
- R10: Writing 1 to bit 0 or bit 1 of 0x24 clears that flag, and writing 0 leaves it unchanged. When hardware sets a flag on the same edge as a clear, the set wins.
- R11: The key and code fields of the control register read back the last values written while the sequencer was idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write access |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| dbg_en | input | 1 | Debug port enabled; erase permitted only when high |
| irq | output | 1 | Interrupt request |

## Verification
The done flag is set by the sequencer and cleared by a write-one-to-clear from software, and both can land on the same edge. The bench starts an accepted erase and then times a clear of the done bit so that its write edge falls from two cycles before to two cycles after the edge where the countdown ends. The expected flag after each attempt is computed from the offset: it stays set when the clear lands at or before the completion edge, and is gone when the clear lands after it.

// File: rtl/fme_pkg.sv
package fme_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_REJECT = 2'd2
    } seq_state_t;

    localparam int REG_W = 32;

    // register offsets
    localparam int OFS_PTR  = 'h00;
    localparam int OFS_CDIV = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_INT  = 'h24;
    localparam int OFS_DATA = 'h30;
    localparam int OFS_WIN  = 'h40;

    // control field positions
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_CODE_LSB = 8;
    localparam int CTRL_BUSY_BIT = 24;
    localparam int CTRL_KEY_LSB  = 28;

    // interrupt register positions
    localparam int INT_DONE_BIT = 0;
    localparam int INT_FAIL_BIT = 1;
    localparam int INT_IE_LSB   = 8;

    localparam logic [3:0] UNLOCK_KEY = 4'h2;
    localparam logic [7:0] WIPE_CODE  = 8'hAA;

    typedef struct packed {
        logic [3:0] key;
        logic [7:0] code;
        logic       go;
    } erase_cmd_t;

endpackage

// File: rtl/fme_regs.sv
module fme_regs
    import fme_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CDIV_W = 8,
    parameter int NDATA  = 4,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [REG_W-1:0]    pwdata,
    output logic [REG_W-1:0]    prdata,
    input  logic                seq_idle,
    input  logic                busy,
    input  logic [1:0]          flags,
    input  logic [1:0]          ie,
    input  logic [REG_W-1:0]    flash_rdata,
    output logic                cmd_wr,
    output erase_cmd_t          cmd,
    output logic                int_wr,
    output logic [1:0]          int_clr,
    output logic [1:0]          int_ie,
    output logic [IDX_W-1:0]    rd_idx
);

    localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(OFS_PTR);
    localparam logic [ADDR_W-1:0] A_CDIV = ADDR_W'(OFS_CDIV);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(OFS_INT);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(OFS_WIN);

    logic              wr_en;
    logic [REG_W-1:0]  ptr_q;
    logic [CDIV_W-1:0] cdiv_q;
    logic [3:0]        key_q;
    logic [7:0]        code_q;
    logic [REG_W-1:0]  data_q [NDATA];

    assign wr_en = psel && penable && pwrite;

    // command decode toward the sequencer
    assign cmd.key  = pwdata[CTRL_KEY_LSB +: 4];
    assign cmd.code = pwdata[CTRL_CODE_LSB +: 8];
    assign cmd.go   = pwdata[CTRL_GO_BIT];
    assign cmd_wr   = wr_en && (paddr == A_CTRL) && seq_idle;

    assign int_wr  = wr_en && (paddr == A_INT);
    assign int_clr = {pwdata[INT_FAIL_BIT], pwdata[INT_DONE_BIT]};
    assign int_ie  = pwdata[INT_IE_LSB +: 2];

    assign rd_idx = ptr_q[IDX_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cdiv_q <= '0;
            key_q  <= '0;
            code_q <= '0;
            for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
        end else begin
            if (wr_en && paddr == A_PTR)  ptr_q  <= pwdata;
            if (wr_en && paddr == A_CDIV) cdiv_q <= pwdata[CDIV_W-1:0];
            if (cmd_wr) begin
                key_q  <= cmd.key;
                code_q <= cmd.code;
            end
            for (int i = 0; i < NDATA; i++) begin
                if (wr_en && paddr == ADDR_W'(OFS_DATA + 4*i)) data_q[i] <= pwdata;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (paddr == A_PTR) begin
            prdata = ptr_q;
        end else if (paddr == A_CDIV) begin
            prdata[CDIV_W-1:0] = cdiv_q;
        end else if (paddr == A_CTRL) begin
            prdata[CTRL_KEY_LSB +: 4]  = key_q;
            prdata[CTRL_CODE_LSB +: 8] = code_q;
            prdata[CTRL_BUSY_BIT]      = busy;
            prdata[CTRL_GO_BIT]        = busy;
        end else if (paddr == A_INT) begin
            prdata[INT_DONE_BIT]     = flags[0];
            prdata[INT_FAIL_BIT]     = flags[1];
            prdata[INT_IE_LSB +: 2]  = ie;
        end else if (paddr == A_WIN) begin
            prdata = flash_rdata;
        end
        for (int i = 0; i < NDATA; i++) begin
            if (paddr == ADDR_W'(OFS_DATA + 4*i)) prdata = data_q[i];
        end
    end

endmodule

// File: rtl/fme_seq.sv
module fme_seq
    import fme_pkg::*;
#(
    parameter int ERASE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  erase_cmd_t cmd,
    input  logic       dbg_en,
    output logic       busy,
    output logic       seq_idle,
    output logic       set_done,
    output logic       set_fail,
    output logic       wipe
);

    localparam int CNT_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             cmd_ok;

    assign cmd_ok = dbg_en && (cmd.key == UNLOCK_KEY) && (cmd.code == WIPE_CODE);

    // state register and countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_ERASE) cnt <= CNT_LOAD;
            else if (state == ST_ERASE && cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr && cmd.go) nxt = cmd_ok ? ST_ERASE : ST_REJECT;
            end
            ST_ERASE: begin
                if (cnt == '0) nxt = ST_IDLE;
            end
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        seq_idle = 1'b0;
        set_done = 1'b0;
        set_fail = 1'b0;
        unique case (state)
            ST_IDLE:   seq_idle = 1'b1;
            ST_ERASE: begin
                busy     = 1'b1;
                set_done = (cnt == '0);
            end
            ST_REJECT: set_fail = 1'b1;
            default:   seq_idle = 1'b0;
        endcase
        wipe = busy;
    end

endmodule

// File: rtl/fme_irq.sv
module fme_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic       int_wr,
    input  logic [1:0] int_clr,
    input  logic [1:0] int_ie,
    output logic [1:0] flags,
    output logic [1:0] ie,
    output logic       irq
);

    logic [1:0] clr_mask;

    assign clr_mask = int_wr ? int_clr : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            ie    <= '0;
        end else begin
            // hardware set takes precedence over a same-edge clear
            flags <= (flags & ~clr_mask) | {set_fail, set_done};
            if (int_wr) ie <= int_ie;
        end
    end

    assign irq = |(flags & ie);

endmodule

// File: rtl/fme_flash_array.sv
module fme_flash_array #(
    parameter int WORDS = 16,
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] words [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (wipe) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '1;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/flash_mass_erase.sv
module flash_mass_erase
    import fme_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int ERASE_CYCLES = 64,
    parameter int FLASH_WORDS  = 16,
    parameter int NDATA        = 4,
    parameter int CDIV_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              dbg_en,
    output logic              irq
);

    localparam int IDX_W = (FLASH_WORDS > 2) ? $clog2(FLASH_WORDS) : 1;

    logic             busy, seq_idle, set_done, set_fail, wipe;
    logic             cmd_wr, int_wr;
    erase_cmd_t       cmd;
    logic [1:0]       int_clr, int_ie, flags, ie;
    logic [IDX_W-1:0] rd_idx;
    logic [REG_W-1:0] flash_rdata;

    fme_regs #(
        .ADDR_W(ADDR_W), .CDIV_W(CDIV_W), .NDATA(NDATA), .IDX_W(IDX_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .seq_idle(seq_idle), .busy(busy), .flags(flags), .ie(ie),
        .flash_rdata(flash_rdata),
        .cmd_wr(cmd_wr), .cmd(cmd),
        .int_wr(int_wr), .int_clr(int_clr), .int_ie(int_ie),
        .rd_idx(rd_idx)
    );

    fme_seq #(.ERASE_CYCLES(ERASE_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd(cmd), .dbg_en(dbg_en),
        .busy(busy), .seq_idle(seq_idle),
        .set_done(set_done), .set_fail(set_fail), .wipe(wipe)
    );

    fme_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .set_done(set_done), .set_fail(set_fail),
        .int_wr(int_wr), .int_clr(int_clr), .int_ie(int_ie),
        .flags(flags), .ie(ie), .irq(irq)
    );

    fme_flash_array #(.WORDS(FLASH_WORDS), .W(REG_W), .IDX_W(IDX_W)) array_i (
        .clk(clk), .rst_n(rst_n), .wipe(wipe),
        .rd_idx(rd_idx), .rd_data(flash_rdata)
    );

endmodule

// File: rtl/fme_chk.sv
module fme_chk
    import fme_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int ERASE_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              wr_go,
    input logic              dbg_en,
    input logic              busy,
    input logic              seq_idle,
    input logic              set_done,
    input logic [1:0]        flags,
    input logic [1:0]        ie,
    input logic              irq
);

    logic        ctrl_bus_wr;
    logic [31:0] busy_len;

    assign ctrl_bus_wr = psel && penable && pwrite && (paddr == ADDR_W'(OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_len <= '0;
        else        busy_len <= busy ? busy_len + 32'd1 : 32'd0;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < 32'(ERASE_CYCLES)));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(ERASE_CYCLES)));

    // R5
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flags[0]);

    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bus_wr && wr_go && seq_idle && !dbg_en) |=> !busy ##1 flags[1]);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_bus_wr && !set_done) |=> busy);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |-> !irq);

    // R9
    irq_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && ie[1]) |-> irq);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> flags[0]);

endmodule

bind flash_mass_erase fme_chk #(
    .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wr_go(pwdata[0]), .dbg_en(dbg_en),
    .busy(busy), .seq_idle(seq_idle), .set_done(set_done),
    .flags(flags), .ie(ie), .irq(irq)
);

// File: tb/flash_mass_erase_tb_top.sv
module flash_mass_erase_tb_top;

    localparam int N  = 6;
    localparam int WD = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0, dbg_en = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          irq;
    logic [31:0]   v;
    int            total = 0, bad = 0;
    bit            ended = 1'b0;

    always #4 clk = ~clk;

    flash_mass_erase #(
        .ADDR_W(AW), .ERASE_CYCLES(N), .FLASH_WORDS(WD), .NDATA(4), .CDIV_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .dbg_en(dbg_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // at most three calls between consecutive falling edges
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        paddr = a;
        #1;
        d = prdata;
    endtask

    task automatic check_array(input string req, input logic [31:0] exp);
        for (int i = 0; i < WD; i++) begin
            wr(12'h000, 32'(i * 4));
            rd(12'h040, v);
            chk(req, v, exp);
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] codes [4];
        codes[0] = 8'hAA; codes[1] = 8'h55; codes[2] = 8'hAB; codes[3] = 8'h2A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(12'h000, v); chk("R1 ptr", v, 32'h0);
        rd(12'h004, v); chk("R1 cdiv", v, 32'h0);
        @(negedge clk);
        rd(12'h008, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h024, v); chk("R1 int", v, 32'h0);
        rd(12'h030, v); chk("R1 data0", v, 32'h0);
        check_array("R1 array", 32'h0);

        // R2 map
        wr(12'h000, 32'hDEAD_BEEC);
        @(negedge clk); rd(12'h000, v); chk("R2 ptr", v, 32'hDEAD_BEEC);
        wr(12'h004, 32'hFFFF_FFFF);
        @(negedge clk); rd(12'h004, v); chk("R2 cdiv", v, 32'h0000_00FF);
        for (int i = 0; i < 4; i++) wr(12'(12'h030 + 4 * i), 32'h1111_1111 * (i + 1));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rd(12'(12'h030 + 4 * i), v);
            chk("R2 data", v, 32'h1111_1111 * (i + 1));
        end
        @(negedge clk); rd(12'h010, v); chk("R2 unmapped", v, 32'h0);

        // R11 field readback without start
        wr(12'h008, 32'h2000_AA00);
        @(negedge clk); rd(12'h008, v); chk("R11 ctrl readback", v, 32'h2000_AA00);

        // R3/R7 sweep: refusals first (array must stay zero), then enabled
        for (int dbg = 0; dbg < 2; dbg++) begin
            dbg_en = (dbg == 1);
            wr(12'h000, 32'h0);
            for (int key = 0; key < 16; key++) begin
                for (int c = 0; c < 4; c++) begin
                    bit acc;
                    acc = (dbg == 1) && (key == 2) && (codes[c] == 8'hAA);
                    wr(12'h024, 32'h3);
                    wr(12'h008, (32'(key) << 28) | (32'(codes[c]) << 8) | 32'h1);
                    @(negedge clk);
                    rd(12'h008, v);
                    chk("R3 busy after start", {31'b0, v[24]}, {31'b0, acc});
                    rd(12'h024, v);
                    chk("R7 fail flag", {31'b0, v[1]}, {31'b0, !acc});
                    if (acc) begin
                        rd(12'h040, v); chk("R6 mid-erase word", v, 32'hFFFF_FFFF);
                        repeat (N - 2) @(negedge clk);
                        rd(12'h008, v); chk("R4 busy last cycle", {v[24], v[0]}, 2'b11);
                        @(negedge clk);
                        rd(12'h008, v); chk("R4 busy cleared", {v[24], v[0]}, 2'b00);
                        rd(12'h024, v); chk("R5 done set", v[1:0], 2'b01);
                        chk("R9 irq without enable", {31'b0, irq}, 32'h0);
                    end
                end
            end
            if (dbg == 0) check_array("R6 refused leaves array", 32'h0);
        end
        check_array("R6 erased array", 32'hFFFF_FFFF);

        // R8 control write while busy
        dbg_en = 1'b1;
        wr(12'h024, 32'h3);
        wr(12'h008, 32'h2000_AA01);
        wr(12'h008, 32'h0000_5501);
        repeat (2) @(negedge clk);
        rd(12'h008, v); chk("R8 still busy", {31'b0, v[24]}, 32'h1);
        @(negedge clk);
        rd(12'h008, v); chk("R8 fields kept, idle", v, 32'h2000_AA00);
        rd(12'h024, v); chk("R8 done only", v[1:0], 2'b01);

        // R9 interrupt enables with both flags
        dbg_en = 1'b0;
        wr(12'h008, 32'h2000_AA01);
        repeat (2) @(negedge clk);
        for (int e = 0; e < 4; e++) begin
            wr(12'h024, 32'(e) << 8);
            @(negedge clk);
            chk("R9 irq both flags", {31'b0, irq}, {31'b0, (e != 0)});
        end
        wr(12'h024, 32'h301);
        @(negedge clk);
        rd(12'h024, v); chk("R10 clear done only", v[1:0], 2'b10);
        chk("R9 irq fail enabled", {31'b0, irq}, 32'h1);
        wr(12'h024, 32'h102);
        @(negedge clk);
        rd(12'h024, v); chk("R10 clear fail", v, 32'h0000_0100);
        chk("R9 irq no flags", {31'b0, irq}, 32'h0);

        // R10 collision sweep: clear-done write edge at E0+N+d
        dbg_en = 1'b1;
        for (int d = -2; d <= 2; d++) begin
            wr(12'h024, 32'h3);
            wr(12'h008, 32'h2000_AA01);
            repeat (N - 3 + d) @(negedge clk);
            wr(12'h024, 32'h1);
            repeat (3 - d) @(negedge clk);
            rd(12'h024, v);
            chk("R10 set vs clear", {31'b0, v[0]}, {31'b0, (d <= 0)});
        end

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule